// File: doc/BRIEF.md
# Video Processor Host Write Port

This block is the processor-facing write side of a tile-based video display controller. A host CPU reaches it through two byte-wide write streams. The control stream carries bytes in pairs. The first byte of a pair is held, and the second byte either commits the held byte into one of eight configuration registers or turns the two bytes into a 14-bit video memory address. The data stream writes bytes into video memory. Each byte goes to the current address, and the address then steps forward by one. Tile patterns (eight bytes each) and whole name tables (768 bytes) can therefore be streamed without setting the address again.

Both input streams use valid/ready. The data stream never applies back-pressure: `dat_ready` is always high. The control stream is held off (`ctl_ready` low) in any cycle where `dat_valid` is high, so the two are never accepted in the same cycle and the data byte wins. On the memory side the block issues a single-cycle write strobe with address and data, and the memory is expected to take it unconditionally. The register contents are always visible, and the colour register is split out into foreground and background nibbles.

Top module: `vdp_host_port`

## Requirements
- R1: A control byte accepted while no byte is held is only latched: registers, address and memory writes are unaffected until the second byte arrives.
- R2: A second control byte with bit 7 = 1 writes the held byte into register number `second[2:0]`. Bits 6:3 of that byte are ignored. Register i appears on `regs_flat[8*i+7 : 8*i]`.
- R3: A second control byte with bits 7:6 = 01 sets the write address to `{second[5:0], held}`. For example, 0x00 followed by 0x48 gives 0x0800.
- R4: A second control byte with bits 7:6 = 00 also sets the address to `{second[5:0], held}` but causes no memory write.
- R5: A data byte accepted at a clock edge produces `vram_wr` = 1 on the next cycle, with `vram_addr` equal to the address current at acceptance and `vram_data` equal to that byte.
- R6: Each accepted data byte advances the address by one, so back-to-back data bytes fill consecutive locations.
- R7: The address is 14 bits wide and wraps from 0x3FFF to 0x0000.
- R8: Any accepted data byte discards a half-received control pair, so the next control byte is treated as a first byte.
- R9: After reset all registers are zero, the address is 0x0000, no control byte is held and `vram_wr` is 0.
- R10: `fg_color` shows bits 7:4 of register 7, and `bg_color` shows bits 3:0 of register 7.
- R11: `dat_ready` is always 1. `ctl_ready` is 0 whenever `dat_valid` is 1, and a control byte offered in that cycle is not taken.
- R12: `vram_wr` is high only in the cycle after an accepted data byte. A single data byte gives a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_valid | input | 1 | Control byte offered |
| ctl_ready | output | 1 | Control byte can be accepted |
| ctl_byte | input | 8 | Control byte |
| dat_valid | input | 1 | Data byte offered |
| dat_ready | output | 1 | Data byte can be accepted (always 1) |
| dat_byte | input | 8 | Data byte |
| vram_wr | output | 1 | Video memory write strobe |
| vram_addr | output | 14 | Video memory write address |
| vram_data | output | 8 | Video memory write data |
| regs_flat | output | 64 | All eight registers, register i in bits 8i+7:8i |
| fg_color | output | 4 | Foreground colour from register 7 |
| bg_color | output | 4 | Background colour from register 7 |

## Verification
The hardest case to reach is a control pair broken by a data byte. The held first byte must be discarded, and the test only shows the bug if the following bytes would decode to something different when misaligned. The stimulus sends a lone first byte, then a data byte, then a full register pair whose first byte would read as an address-setup second byte if the latch had survived. The resulting register value exposes the fault. The address wrap is reached by setting the address just below 0x3FFF through the control stream and streaming three bytes across the boundary.

// File: rtl/vhp_pkg.sv
package vhp_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_FIRST,
    ACT_REG,
    ACT_WSETUP,
    ACT_RSETUP
  } ctl_action_e;
endpackage

// File: rtl/vhp_ctl_decode.sv
module vhp_ctl_decode
  import vhp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 14,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_fire,
  input  logic              dat_fire,
  input  logic [DATA_W-1:0] ctl_byte,
  output logic              reg_we,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] reg_val,
  output logic              addr_ld,
  output logic [ADDR_W-1:0] addr_val
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic              pending;
  logic [DATA_W-1:0] held;
  ctl_action_e       act;

  always_comb begin
    act = ACT_NONE;
    if (ctl_fire) begin
      if (!pending)                act = ACT_FIRST;
      else if (ctl_byte[DATA_W-1]) act = ACT_REG;
      else if (ctl_byte[DATA_W-2]) act = ACT_WSETUP;
      else                         act = ACT_RSETUP;
    end
  end

  assign reg_we   = (act == ACT_REG);
  assign reg_idx  = ctl_byte[IDX_W-1:0];
  assign reg_val  = held;
  assign addr_ld  = (act == ACT_WSETUP) || (act == ACT_RSETUP);
  assign addr_val = {ctl_byte[HI_W-1:0], held};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      held    <= '0;
    end else if (dat_fire) begin
      pending <= 1'b0;
    end else if (act == ACT_FIRST) begin
      pending <= 1'b1;
      held    <= ctl_byte;
    end else if (act != ACT_NONE) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/vhp_addr_ctr.sv
module vhp_addr_ctr #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              dat_fire,
  input  logic [DATA_W-1:0] dat_byte,
  output logic              vram_wr,
  output logic [ADDR_W-1:0] vram_addr,
  output logic [DATA_W-1:0] vram_data
);
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      vram_wr   <= 1'b0;
      vram_addr <= '0;
      vram_data <= '0;
    end else begin
      vram_wr <= dat_fire;
      if (dat_fire) begin
        vram_addr <= ptr;
        vram_data <= dat_byte;
        ptr       <= ptr + 1'b1;
      end else if (addr_ld) begin
        ptr <= addr_val;
      end
    end
  end
endmodule

// File: rtl/vhp_reg_file.sv
module vhp_reg_file #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [IDX_W-1:0]           reg_idx,
  input  logic [DATA_W-1:0]          reg_val,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                               q <= '0;
      else if (reg_we && reg_idx == IDX_W'(i))  q <= reg_val;
    end
    assign regs_flat[i*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/vdp_host_port.sv
module vdp_host_port #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 14,
  parameter int NUM_REGS  = 8,
  parameter int COLOR_REG = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctl_valid,
  output logic                       ctl_ready,
  input  logic [DATA_W-1:0]          ctl_byte,
  input  logic                       dat_valid,
  output logic                       dat_ready,
  input  logic [DATA_W-1:0]          dat_byte,
  output logic                       vram_wr,
  output logic [ADDR_W-1:0]          vram_addr,
  output logic [DATA_W-1:0]          vram_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output logic [DATA_W/2-1:0]        fg_color,
  output logic [DATA_W/2-1:0]        bg_color
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int NIB_W = DATA_W / 2;

  logic              ctl_fire, dat_fire;
  logic              reg_we, addr_ld;
  logic [IDX_W-1:0]  reg_idx;
  logic [DATA_W-1:0] reg_val;
  logic [ADDR_W-1:0] addr_val;

  assign dat_ready = 1'b1;
  assign ctl_ready = ~dat_valid;
  assign dat_fire  = dat_valid;
  assign ctl_fire  = ctl_valid & ctl_ready;

  vhp_ctl_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .ctl_fire(ctl_fire), .dat_fire(dat_fire),
    .ctl_byte(ctl_byte), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_val(reg_val), .addr_ld(addr_ld), .addr_val(addr_val)
  );

  vhp_addr_ctr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_val(addr_val),
    .dat_fire(dat_fire), .dat_byte(dat_byte), .vram_wr(vram_wr),
    .vram_addr(vram_addr), .vram_data(vram_data)
  );

  vhp_reg_file #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_val(reg_val), .regs_flat(regs_flat)
  );

  assign fg_color = regs_flat[COLOR_REG*DATA_W + NIB_W +: NIB_W];
  assign bg_color = regs_flat[COLOR_REG*DATA_W +: NIB_W];
endmodule

// File: rtl/vhp_host_port_chk.sv
module vhp_host_port_chk #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 14,
  parameter int NUM_REGS = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ctl_ready,
  input logic                       dat_valid,
  input logic                       dat_ready,
  input logic [DATA_W-1:0]          dat_byte,
  input logic                       vram_wr,
  input logic [ADDR_W-1:0]          vram_addr,
  input logic [DATA_W-1:0]          vram_data,
  input logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  AST_WR_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    vram_wr |-> $past(dat_valid));                                           // R5
  AST_WR_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    vram_wr |-> vram_data == $past(dat_byte));                               // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_wr && $past(vram_wr)) |-> vram_addr == ADDR_W'($past(vram_addr) + 1'b1)); // R6
  AST_CTL_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |-> (!ctl_ready && dat_ready));                                 // R11
  AST_REGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |=> $stable(regs_flat));                                        // R11
  AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_valid |=> !vram_wr);                                                 // R12
endmodule

bind vdp_host_port vhp_host_port_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
) u_chk (.*);

// File: tb/tb_vdp_host_port.sv
module tb_vdp_host_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_valid = 1'b0, dat_valid = 1'b0;
  logic [7:0]  ctl_byte = '0, dat_byte = '0;
  logic        ctl_ready, dat_ready, vram_wr;
  logic [13:0] vram_addr;
  logic [7:0]  vram_data;
  logic [63:0] regs_flat;
  logic [3:0]  fg_color, bg_color;

  int total = 0;
  int bad   = 0;
  string cur_tag = "R9";

  logic [21:0] exp_q[$];
  logic [13:0] exp_addr = '0;
  logic [7:0]  exp_regs [8];
  logic        pend = 1'b0;
  logic [7:0]  held = '0;

  always #4 clk = ~clk;

  vdp_host_port dut (
    .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
    .ctl_byte(ctl_byte), .dat_valid(dat_valid), .dat_ready(dat_ready),
    .dat_byte(dat_byte), .vram_wr(vram_wr), .vram_addr(vram_addr),
    .vram_data(vram_data), .regs_flat(regs_flat), .fg_color(fg_color),
    .bg_color(bg_color)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] regs_model();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = exp_regs[i];
    return v;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && vram_wr) begin
      if (exp_q.size() == 0) begin
        chk({cur_tag, " unexpected write"}, {42'd0, vram_addr, vram_data}, 64'hFFFF_FFFF);
      end else begin
        logic [21:0] e;
        e = exp_q.pop_front();
        chk({cur_tag, " R5 write"}, {42'd0, vram_addr, vram_data}, {42'd0, e});
      end
    end
  end

  task automatic ctl_send(logic [7:0] b);
    @(negedge clk);
    ctl_valid = 1'b1;
    ctl_byte  = b;
    @(negedge clk);
    ctl_valid = 1'b0;
    if (!pend) begin
      pend = 1'b1;
      held = b;
    end else begin
      pend = 1'b0;
      if (b[7]) exp_regs[b[2:0]] = held;
      else      exp_addr = {b[5:0], held};
    end
  endtask

  task automatic dat_burst(int n, logic [7:0] v, bit inc);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      dat_valid = 1'b1;
      dat_byte  = inc ? v + 8'(k) : v;
      exp_q.push_back({exp_addr, dat_byte});
      exp_addr++;
    end
    @(negedge clk);
    dat_valid = 1'b0;
    pend = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) exp_regs[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 regs", regs_flat, 64'd0);
    chk("R9 strobe", {63'd0, vram_wr}, 64'd0);
    chk("R11 dat_ready", {63'd0, dat_ready}, 64'd1);
    dat_burst(1, 8'hA5, 0);                       // R9 address starts at zero
    @(negedge clk);
    cur_tag = "R12";
    chk("R12 pulse ends", {63'd0, vram_wr}, 64'd0);

    cur_tag = "R3";
    ctl_send(8'h00); ctl_send(8'h48);
    dat_burst(8, 8'hAA, 0);                       // R3 + R6 tile fill
    cur_tag = "R6";
    dat_burst(4, 8'h10, 1);

    cur_tag = "R2";
    ctl_send(8'hF0); ctl_send(8'h87);
    chk("R2 reg7", regs_flat, regs_model());
    chk("R10 fg", {60'd0, fg_color}, 64'hF);
    chk("R10 bg", {60'd0, bg_color}, 64'h0);
    ctl_send(8'h3C); ctl_send(8'hFA);             // R2 bits 6:3 ignored -> reg 2
    chk("R2 reg2", regs_flat, regs_model());
    ctl_send(8'h5A); ctl_send(8'h87);
    chk("R10 fg2", {60'd0, fg_color}, 64'h5);
    chk("R10 bg2", {60'd0, bg_color}, 64'hA);

    cur_tag = "R1";
    ctl_send(8'h77);
    chk("R1 regs untouched", regs_flat, regs_model());
    cur_tag = "R8";
    dat_burst(1, 8'h3E, 0);                       // R1 write lands on old address
    ctl_send(8'h05); ctl_send(8'h81);             // R8 latch was cleared
    chk("R8 reg1", regs_flat, regs_model());

    cur_tag = "R4";
    ctl_send(8'h34); ctl_send(8'h12);
    repeat (4) @(negedge clk);
    chk("R4 no write", {63'd0, vram_wr}, 64'd0);
    chk("R4 queue empty", 64'(exp_q.size()), 64'd0);
    dat_burst(1, 8'h11, 0);

    cur_tag = "R7";
    ctl_send(8'hFE); ctl_send(8'h7F);
    dat_burst(3, 8'hC0, 1);

    cur_tag = "R6";
    ctl_send(8'h00); ctl_send(8'h78);
    dat_burst(768, 8'h00, 0);

    cur_tag = "R11";
    @(negedge clk);
    ctl_valid = 1'b1; ctl_byte = 8'h83;
    dat_valid = 1'b1; dat_byte = 8'h66;
    exp_q.push_back({exp_addr, 8'h66});
    exp_addr++;
    #1;
    chk("R11 ctl held off", {62'd0, ctl_ready, dat_ready}, 64'd1);
    @(negedge clk);
    ctl_valid = 1'b0; dat_valid = 1'b0; pend = 1'b0;
    @(negedge clk);
    chk("R11 regs unchanged", regs_flat, regs_model());

    repeat (3) @(negedge clk);
    chk("R5 queue drained", 64'(exp_q.size()), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule